// File: doc/BRIEF.md
# Link Time-Window Analysis Counter

This block measures one chosen link quantity over a measurement window and keeps the result in a wide counter. The quantity can be the clock cycle itself, cycles spent in one of several link power states, or payload moved in either direction for two traffic classes. Payload is counted in 16-byte units. The link logic supplies a one-hot state vector and per-cycle payload increments. The block does not decode any of this; it only adds what it is given.

Software programs a single control word. That word holds a report selector, a window selector and a start bit. Software then reads the result as two 32-bit words. The window is either a fixed length, from 4 microseconds up to 4 seconds, derived from a clock-frequency parameter, or it stays open until software clears the start bit. Each start empties the counter first. The two result words are not captured together, so a reader that wants a consistent value reads the high word again after the low word until it matches. No interrupt is raised, and the counter stops at all-ones rather than wrapping.

Top module: `linkTimeCounter`

## Requirements
- R1: Register map on `regAddr`: control at 0x10, result low word at 0x14, result high word at 0x18; any other offset reads zero. The control word reads back the report selector in bits 31:24, the window selector in bits 15:8 and the run status in bit 0; all other bits read zero.
- R2: A control write with bit 0 set starts a measurement. The counter reads zero right after that write edge, and counting begins with the following cycle.
- R3: Report selector 0x00 adds one for every cycle of the measurement.
- R4: Report selectors 0x01 to 0x09 add one for each cycle in which `linkState` bit (selector − 1) is high. In order, the bits are TX L0s, RX L0s, L0, L1, L1.1, L1.2, configuration/recovery, combined TX/RX L0s and L1 auxiliary.
- R5: Report selectors 0x20, 0x21, 0x22 and 0x23 add the per-cycle value of `txPayloadInc`, `rxPayloadInc`, `txAltPayloadInc` and `rxAltPayloadInc` respectively. Each value is in 16-byte units.
- R6: Window selectors 0x01, 0x02, 0x03, 0x04, 0x05, 0x06 and 0xFF give fixed windows of 1 ms, 10 ms, 100 ms, 1 s, 2 s, 4 s and 4 us, computed as cycles of `CLK_FREQ_HZ` (at least one cycle). Exactly that many cycles are counted. Control bit 0 then reads 0 and the result holds.
- R7: Window selector 0x00, and any selector not listed in R6, keeps the measurement running until software writes control bit 0 as 0. The cycle of that write is still counted, and the result then holds.
- R8: The counter saturates at all-ones and never wraps.
- R9: A report selector not listed in R3 to R5 adds nothing, so the counter stays at zero after a start.
- R10: After reset the control word and both result words read zero.
- R11: Writes to the result offsets are ignored and do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe, one cycle per write |
| regAddr | input | ADDR_W | Register byte offset for writes and reads |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Read data for `regAddr`, combinational |
| linkState | input | STATE_N | One-hot link power-state indication |
| txPayloadInc | input | INC_W | TX payload this cycle, 16-byte units |
| rxPayloadInc | input | INC_W | RX payload this cycle, 16-byte units |
| txAltPayloadInc | input | INC_W | TX payload of the second traffic class, 16-byte units |
| rxAltPayloadInc | input | INC_W | RX payload of the second traffic class, 16-byte units |

## Verification
The properties assume that `regWrEn` pulses for one cycle per write and that `linkState` carries at most one set bit. They also assume the payload inputs are already valid increments, because the counter adds them without question. The directed stimulus only changes inputs on the falling clock edge. It drives one-hot state patterns, holds each payload value steady over a window, and issues every control write as a one-cycle pulse. The saturation property is reached by shrinking the counter width and widening the payload increment at the bench's parameter override, so all-ones is hit within about a thousand cycles.

// File: rtl/ltcPkg.sv
package ltcPkg;

  localparam logic [7:0] RPT_CYCLE    = 8'h00;
  localparam logic [7:0] RPT_PAY_BASE = 8'h20;
  localparam int         PAY_N        = 4;

  localparam logic [7:0] DUR_MANUAL = 8'h00;
  localparam logic [7:0] DUR_1MS    = 8'h01;
  localparam logic [7:0] DUR_10MS   = 8'h02;
  localparam logic [7:0] DUR_100MS  = 8'h03;
  localparam logic [7:0] DUR_1S     = 8'h04;
  localparam logic [7:0] DUR_2S     = 8'h05;
  localparam logic [7:0] DUR_4S     = 8'h06;
  localparam logic [7:0] DUR_4US    = 8'hFF;

  localparam logic [7:0] OFF_CTRL = 8'h10;
  localparam logic [7:0] OFF_LO   = 8'h14;
  localparam logic [7:0] OFF_HI   = 8'h18;

  // strobes from the control side to the datapath
  typedef struct packed {
    logic clear;
    logic count;
  } ltcStrobe_t;

  function automatic logic isFixedDur(input logic [7:0] code);
    return (code inside {DUR_1MS, DUR_10MS, DUR_100MS, DUR_1S, DUR_2S, DUR_4S, DUR_4US});
  endfunction

  // window length in cycles for a fixed-duration code, never below one
  function automatic longint unsigned durCycles(input logic [7:0] code,
                                                input longint unsigned hz);
    longint unsigned c;
    case (code)
      DUR_1MS:   c = hz / 1000;
      DUR_10MS:  c = hz / 100;
      DUR_100MS: c = hz / 10;
      DUR_1S:    c = hz;
      DUR_2S:    c = hz * 2;
      DUR_4S:    c = hz * 4;
      DUR_4US:   c = (hz * 4) / 1_000_000;
      default:   c = 1;
    endcase
    if (c == 0) c = 1;
    return c;
  endfunction

endpackage

// File: rtl/ltcControl.sv
module ltcControl
  import ltcPkg::*;
#(
  parameter longint unsigned CLK_FREQ_HZ = 125_000_000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctrlWr,
  input  logic       startIn,
  input  logic [7:0] reportIn,
  input  logic [7:0] durIn,
  output logic [7:0] reportSel,
  output logic [7:0] durSel,
  output logic       running,
  output ltcStrobe_t strobes
);

  localparam longint unsigned MAX_CYC = 4 * CLK_FREQ_HZ;
  localparam int TMR_W = $clog2(MAX_CYC + 1);

  logic [TMR_W-1:0] remaining;
  logic             startNow;

  assign startNow = ctrlWr && startIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reportSel <= '0;
      durSel    <= '0;
      running   <= 1'b0;
      remaining <= '0;
    end else if (ctrlWr) begin
      reportSel <= reportIn;
      durSel    <= durIn;
      running   <= startIn;
      if (startIn) remaining <= TMR_W'(durCycles(durIn, CLK_FREQ_HZ));
    end else if (running && isFixedDur(durSel)) begin
      if (remaining <= TMR_W'(1)) running <= 1'b0;
      else                        remaining <= remaining - TMR_W'(1);
    end
  end

  // a restart wins over counting in the same cycle; a stop write still counts
  always_comb begin
    strobes.clear = startNow;
    strobes.count = running && !startNow;
  end

endmodule

// File: rtl/ltcDatapath.sv
module ltcDatapath
  import ltcPkg::*;
#(
  parameter int CNT_W   = 64,
  parameter int INC_W   = 8,
  parameter int STATE_N = 9
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ltcStrobe_t                 strobes,
  input  logic [7:0]                 reportSel,
  input  logic [STATE_N-1:0]         linkState,
  input  logic [PAY_N-1:0][INC_W-1:0] payloadInc,
  output logic [CNT_W-1:0]           cnt
);

  logic [INC_W-1:0] incVal;
  logic [CNT_W:0]   sumExt;

  always_comb begin
    incVal = '0;
    if (reportSel == RPT_CYCLE) incVal = INC_W'(1);
    for (int k = 0; k < STATE_N; k++) begin
      if (reportSel == 8'(k + 1)) incVal = INC_W'(linkState[k]);
    end
    for (int p = 0; p < PAY_N; p++) begin
      if (reportSel == RPT_PAY_BASE + 8'(p)) incVal = payloadInc[p];
    end
  end

  assign sumExt = {1'b0, cnt} + (CNT_W + 1)'(incVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cnt <= '0;
    else if (strobes.clear) cnt <= '0;
    else if (strobes.count) cnt <= sumExt[CNT_W] ? '1 : sumExt[CNT_W-1:0];
  end

endmodule

// File: rtl/linkTimeCounter.sv
module linkTimeCounter
  import ltcPkg::*;
#(
  parameter longint unsigned CLK_FREQ_HZ = 125_000_000,
  parameter int CNT_W   = 64,
  parameter int INC_W   = 8,
  parameter int STATE_N = 9,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [31:0]        regWdata,
  output logic [31:0]        regRdata,
  input  logic [STATE_N-1:0] linkState,
  input  logic [INC_W-1:0]   txPayloadInc,
  input  logic [INC_W-1:0]   rxPayloadInc,
  input  logic [INC_W-1:0]   txAltPayloadInc,
  input  logic [INC_W-1:0]   rxAltPayloadInc
);

  logic                        ctrlWr;
  logic [7:0]                  reportSel;
  logic [7:0]                  durSel;
  logic                        running;
  ltcStrobe_t                  strobes;
  logic [CNT_W-1:0]            cnt;
  logic [63:0]                 cnt64;
  logic [PAY_N-1:0][INC_W-1:0] payloadInc;
  logic                        unusedWdata;

  assign ctrlWr      = regWrEn && (regAddr == ADDR_W'(OFF_CTRL));
  assign payloadInc  = {rxAltPayloadInc, txAltPayloadInc, rxPayloadInc, txPayloadInc};
  assign unusedWdata = ^{regWdata[23:16], regWdata[7:1]};

  ltcControl #(.CLK_FREQ_HZ(CLK_FREQ_HZ)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .ctrlWr    (ctrlWr),
    .startIn   (regWdata[0]),
    .reportIn  (regWdata[31:24]),
    .durIn     (regWdata[15:8]),
    .reportSel (reportSel),
    .durSel    (durSel),
    .running   (running),
    .strobes   (strobes)
  );

  ltcDatapath #(.CNT_W(CNT_W), .INC_W(INC_W), .STATE_N(STATE_N)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .reportSel  (reportSel),
    .linkState  (linkState),
    .payloadInc (payloadInc),
    .cnt        (cnt)
  );

  assign cnt64 = 64'(cnt);

  always_comb begin
    if (regAddr == ADDR_W'(OFF_CTRL))    regRdata = {reportSel, 8'h00, durSel, 7'h00, running};
    else if (regAddr == ADDR_W'(OFF_LO)) regRdata = cnt64[31:0];
    else if (regAddr == ADDR_W'(OFF_HI)) regRdata = cnt64[63:32];
    else                                 regRdata = '0;
  end

endmodule

// File: rtl/ltcChecker.sv
module ltcChecker #(
  parameter int CNT_W   = 64,
  parameter int STATE_N = 9
) (
  input logic             clk,
  input logic             rstN,
  input logic             ctrlWr,
  input logic [31:0]      regWdata,
  input logic [CNT_W-1:0] cnt,
  input logic             running,
  input logic [7:0]       durSel,
  input logic [7:0]       reportSel
);

  logic startNow;
  logic fixedWin;
  logic knownRpt;

  assign startNow = ctrlWr && regWdata[0];
  assign fixedWin = (durSel inside {8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'hFF});
  assign knownRpt = (reportSel <= 8'(STATE_N)) || (reportSel inside {8'h20, 8'h21, 8'h22, 8'h23});

  // R2: a start empties the counter at its edge
  p_start_clears_r2: assert property (@(posedge clk) disable iff (!rstN)
    startNow |=> (cnt == '0));

  // R6: without a run and without a start, the result holds
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !startNow) |=> $stable(cnt));

  // R7: an open window only ends through a control write
  p_manual_keeps_running_r7: assert property (@(posedge clk) disable iff (!rstN)
    (running && !fixedWin && !ctrlWr) |=> running);

  // R8: all-ones is sticky until a restart
  p_saturate_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((cnt == '1) && !startNow) |=> (cnt == '1));

  // R8: no wrap, the value never falls except through a start
  p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rstN)
    !startNow |=> (cnt >= $past(cnt)));

  // R9: unsupported report code adds nothing
  p_unknown_report_r9: assert property (@(posedge clk) disable iff (!rstN)
    (running && !knownRpt && !startNow) |=> $stable(cnt));

endmodule

bind linkTimeCounter ltcChecker #(.CNT_W(CNT_W), .STATE_N(STATE_N)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .ctrlWr    (ctrlWr),
  .regWdata  (regWdata),
  .cnt       (cnt),
  .running   (running),
  .durSel    (durSel),
  .reportSel (reportSel)
);

// File: tb/linkTimeCounter_tb.sv
module linkTimeCounter_tb;

  localparam longint unsigned HZ = 1_000_000;
  localparam int CNT_W   = 34;
  localparam int INC_W   = 24;
  localparam int STATE_N = 9;
  localparam int ADDR_W  = 8;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               regWrEn = 1'b0;
  logic [ADDR_W-1:0]  regAddr = '0;
  logic [31:0]        regWdata = '0;
  logic [31:0]        regRdata;
  logic [STATE_N-1:0] linkState = '0;
  logic [INC_W-1:0]   txPayloadInc = '0;
  logic [INC_W-1:0]   rxPayloadInc = '0;
  logic [INC_W-1:0]   txAltPayloadInc = '0;
  logic [INC_W-1:0]   rxAltPayloadInc = '0;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  linkTimeCounter #(.CLK_FREQ_HZ(HZ), .CNT_W(CNT_W), .INC_W(INC_W),
                    .STATE_N(STATE_N), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .linkState(linkState),
    .txPayloadInc(txPayloadInc), .rxPayloadInc(rxPayloadInc),
    .txAltPayloadInc(txAltPayloadInc), .rxAltPayloadInc(rxAltPayloadInc)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=0x%08h exp=0x%08h", req, got, exp);
    end
  endtask

  // called at a falling edge; the write lands on the next rising edge
  task automatic wr(input logic [7:0] addr, input logic [31:0] data);
    regWrEn  = 1'b1;
    regAddr  = addr;
    regWdata = data;
    @(negedge clk);
    regWrEn  = 1'b0;
  endtask

  task automatic rd(input logic [7:0] addr, output logic [31:0] data);
    regAddr = addr;
    #1;
    data = regRdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tReset();
    logic [31:0] d;
    rd(8'h10, d); check("R10 ctrl", d, 32'h0);
    rd(8'h14, d); check("R10 lo", d, 32'h0);
    rd(8'h18, d); check("R10 hi", d, 32'h0);
  endtask

  task automatic tRegMap();
    logic [31:0] d;
    wr(8'h10, 32'h21A5_0300);
    rd(8'h10, d); check("R1 ctrl readback", d, 32'h2100_0300);
    rd(8'h1C, d); check("R1 unmapped", d, 32'h0);
  endtask

  task automatic tManualCycles();
    logic [31:0] d;
    wr(8'h10, 32'h0000_0001);
    idle(9);
    rd(8'h10, d); check("R7 still running", d, 32'h0000_0001);
    wr(8'h10, 32'h0000_0000);
    rd(8'h14, d); check("R3 cycle count", d, 32'd10);
    rd(8'h18, d); check("R1 hi word", d, 32'h0);
    idle(5);
    rd(8'h14, d); check("R7 hold after stop", d, 32'd10);
  endtask

  task automatic tIgnoreDataWrites();
    logic [31:0] d;
    wr(8'h14, 32'hDEAD_BEEF);
    wr(8'h18, 32'h0000_0003);
    rd(8'h14, d); check("R11 lo unchanged", d, 32'd10);
    rd(8'h18, d); check("R11 hi unchanged", d, 32'h0);
  endtask

  task automatic tLinkState();
    logic [31:0] d;
    linkState = 9'b0_0000_0100;
    wr(8'h10, 32'h0300_0001);
    idle(4);
    linkState = 9'b0_0000_0001;
    idle(3);
    wr(8'h10, 32'h0300_0000);
    rd(8'h14, d); check("R4 L0 cycles", d, 32'd4);
    linkState = 9'b1_0000_0000;
    wr(8'h10, 32'h0900_0001);
    idle(6);
    wr(8'h10, 32'h0900_0000);
    rd(8'h14, d); check("R4 L1 aux cycles", d, 32'd7);
    linkState = '0;
  endtask

  task automatic tPayload();
    logic [31:0] d;
    txPayloadInc = 24'd100;
    rxPayloadInc = 24'd7;
    wr(8'h10, 32'h2100_0001);
    idle(9);
    wr(8'h10, 32'h2100_0000);
    rd(8'h14, d); check("R5 rx payload", d, 32'd70);
    txAltPayloadInc = 24'd3;
    rxAltPayloadInc = 24'd50;
    wr(8'h10, 32'h2200_0001);
    idle(9);
    wr(8'h10, 32'h2200_0000);
    rd(8'h14, d); check("R5 alt tx payload", d, 32'd30);
    txAltPayloadInc = '0;
    rxAltPayloadInc = '0;
    rxPayloadInc = '0;
  endtask

  task automatic tSaturate();
    logic [31:0] d;
    txPayloadInc = '1;
    wr(8'h10, 32'h2000_0001);
    idle(1100);
    wr(8'h10, 32'h2000_0000);
    rd(8'h14, d); check("R8 lo saturated", d, 32'hFFFF_FFFF);
    rd(8'h18, d); check("R8 hi saturated", d, 32'h0000_0003);
    txPayloadInc = '0;
  endtask

  task automatic tUnsupported();
    logic [31:0] d;
    wr(8'h10, 32'h1000_0001);
    rd(8'h14, d); check("R2 cleared at start", d, 32'h0);
    idle(9);
    wr(8'h10, 32'h1000_0000);
    rd(8'h14, d); check("R9 lo stays zero", d, 32'h0);
    rd(8'h18, d); check("R9 hi stays zero", d, 32'h0);
  endtask

  task automatic tFixed4us();
    logic [31:0] d;
    wr(8'h10, 32'h0000_FF01);
    idle(20);
    rd(8'h14, d); check("R6 4us window", d, 32'd4);
    rd(8'h10, d); check("R6 4us self stop", d, 32'h0000_FF00);
  endtask

  task automatic tFixed1ms();
    logic [31:0] d;
    wr(8'h10, 32'h0000_0101);
    idle(500);
    rd(8'h10, d); check("R6 1ms running", d, 32'h0000_0101);
    idle(600);
    rd(8'h14, d); check("R6 1ms window", d, 32'd1000);
    rd(8'h10, d); check("R6 1ms self stop", d, 32'h0000_0100);
  endtask

  task automatic tFixed10ms();
    logic [31:0] d;
    wr(8'h10, 32'h0000_0201);
    idle(10050);
    rd(8'h14, d); check("R6 10ms window", d, 32'd10000);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired got=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(2);
    tReset();
    tRegMap();
    tManualCycles();
    tIgnoreDataWrites();
    tLinkState();
    tPayload();
    tSaturate();
    tUnsupported();
    tFixed4us();
    tFixed1ms();
    tFixed10ms();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule